// File: doc/BRIEF.md
# Hot-Plug Slot Event Latch and Interrupt Locator

This block watches the status lines of a set of hot-plug slots and turns their changes into interrupts. Each slot has one 32-bit register. It shows the live, synchronised state of the slot's presence code, fault lines, attention button, retention latch and 66 MHz capability. It latches every change of those lines as an event, and it holds the per-event interrupt masks and error masks for that slot. One controller register holds the global masks and a latch for arbiter errors.

A read-only locator word gathers everything that needs service. Bit 0 is a pending command completion, and bit i+1 is slot i with at least one unmasked latched event. Software reads the locator to find the slots that need service, reads each flagged slot register, and writes ones back to clear the events it handled. It can set the global interrupt mask while it does this. The block drives one level interrupt and one level system-error output.

Register map: address 0 is the controller register, address 1 is the locator, and address 2+i is slot i. Reads are combinational. Writes take effect on the clock edge where `reg_we_i` is high.

Top module: `slot_event_ctrl`

## Requirements
- R1: After reset, every slot has its seven mask bits (30:24) set and its latches (20:16) clear. The controller register reads 0x0000000B (global interrupt mask bit 0, global error mask bit 1 and arbiter mask bit 3 all set). `irq_o` and `serr_o` are low.
- R2: Slot register status fields are as follows. Bit 6 reads 0 while either fault input of the slot is high. Bit 7 is the button, bit 8 is the latch (1 = open) and bit 9 is 66 MHz capability. Bits 11:10 are the presence code, where 11 means empty. Each field follows its input two clock edges after the input changes.
- R3: A change of the synchronised presence code (either bit) sets bit 16. A change of the isolated fault sets bit 17, a change of the button sets bit 18, a change of the latch sets bit 19 and a change of the connected fault sets bit 20. The latch is set on the third clock edge after the input change. A capability change sets nothing. A set latch stays set until software clears it.
- R4: Writing 1 to a latch bit clears it, and writing 0 leaves it unchanged. If a new event for that bit arrives on the same edge as the clear, the bit stays set.
- R5: Slot bits 28:24 are read/write interrupt masks for the five events, in the same order as bits 20:16. Bit 29 is a read/write error mask for the latch-change event, and bit 30 is a read/write error mask for the connected-fault event. A set mask bit hides its event.
- R6: The following bits read 0 whatever is written to them. In a slot register: bits 5:0, 15:12, 23:21 and 31. In the controller register: bits 2, 16:4 and 31:18.
- R7: The locator (address 1) has bit 0 equal to `cmd_pend_i` and bit i+1 set exactly when slot i holds a latched event whose interrupt mask is clear. All other locator bits read 0. Writes to the locator have no effect.
- R8: `irq_o` is high exactly when the locator is non-zero and the global interrupt mask (controller bit 0) is clear.
- R9: `serr_o` is high exactly when the global error mask (controller bit 1) is clear and at least one of these holds: some slot has a latch-change event with bit 29 clear; some slot has a connected-fault event with bit 30 clear; the arbiter latch (bit 17) is set with the arbiter mask (bit 3) clear.
- R10: A high cycle of `arb_err_i` sets controller bit 17 on the next edge. Writing 1 to bit 17 clears it.
- R11: Input levels that are already present while reset is held latch no event when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pres_code_i | input | 2*NUM_SLOTS | Presence code per slot, 11 = empty |
| button_i | input | NUM_SLOTS | Attention button level per slot |
| latch_open_i | input | NUM_SLOTS | Retention latch open per slot |
| iso_fault_i | input | NUM_SLOTS | Isolated power fault per slot, high = fault |
| con_fault_i | input | NUM_SLOTS | Connected power fault per slot, high = fault |
| cap66_i | input | NUM_SLOTS | 66 MHz capable per slot |
| cmd_pend_i | input | 1 | Command completion pending |
| arb_err_i | input | 1 | Arbiter error pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Level interrupt |
| serr_o | output | 1 | Level system error |

## Verification
Each result has a fixed latency after its stimulus:
- A slot status field changes two edges after its input, through the synchroniser.
- An event latch, and the locator, interrupt and error outputs that follow from it, change on the third edge.
- Register writes, the arbiter latch and the command-pending bit of the locator take effect on the next edge, or at once for the command bit.

The bench drives and samples only at falling edges. It waits four falling edges after a slot input change before it reads, so every path has settled. For the collision case it times the clearing write to land exactly on the third edge after the input change.

// File: rtl/slot_event_ctrl.sv
module slot_event_ctrl #(
  parameter int NUM_SLOTS = 4,
  localparam int AW = $clog2(NUM_SLOTS + 2)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2*NUM_SLOTS-1:0] pres_code_i,
  input  logic [NUM_SLOTS-1:0]   button_i,
  input  logic [NUM_SLOTS-1:0]   latch_open_i,
  input  logic [NUM_SLOTS-1:0]   iso_fault_i,
  input  logic [NUM_SLOTS-1:0]   con_fault_i,
  input  logic [NUM_SLOTS-1:0]   cap66_i,
  input  logic                   cmd_pend_i,
  input  logic                   arb_err_i,
  input  logic                   reg_we_i,
  input  logic [AW-1:0]          reg_addr_i,
  input  logic [31:0]            reg_wdata_i,
  output logic [31:0]            reg_rdata_o,
  output logic                   irq_o,
  output logic                   serr_o
);

  logic [NUM_SLOTS-1:0][6:0] in_raw, s1_q, s2_q, mask_q;
  logic [NUM_SLOTS-1:0][5:0] prev_q;
  logic [NUM_SLOTS-1:0][4:0] latch_q, ev, keep;
  logic [NUM_SLOTS-1:0]      wr_slot, pend, serr_slot;
  logic [NUM_SLOTS-1:0][31:0] slot_word;
  logic [31:0] loc, ctrl_word;
  logic [1:0]  arm_q;
  logic        armed, wr_ctl, gim_q, gserr_q, arbm_q, arb_det_q;
  logic        unused_wdata;

  assign unused_wdata = ^reg_wdata_i;
  assign armed  = (arm_q == 2'd3);
  assign wr_ctl = reg_we_i && (reg_addr_i == AW'(0));

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign in_raw[g] = {cap66_i[g], con_fault_i[g], iso_fault_i[g],
                        latch_open_i[g], button_i[g], pres_code_i[2*g +: 2]};
    assign wr_slot[g] = reg_we_i && (reg_addr_i == AW'(g + 2));
    assign ev[g] = armed ? {s2_q[g][5] ^ prev_q[g][5],
                            s2_q[g][3] ^ prev_q[g][3],
                            s2_q[g][2] ^ prev_q[g][2],
                            s2_q[g][4] ^ prev_q[g][4],
                            |(s2_q[g][1:0] ^ prev_q[g][1:0])} : 5'b0;
    assign keep[g] = wr_slot[g] ? ~reg_wdata_i[20:16] : 5'h1f;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1_q[g]    <= '0;
        s2_q[g]    <= '0;
        prev_q[g]  <= '0;
        latch_q[g] <= '0;
        mask_q[g]  <= '1;
      end else begin
        s1_q[g]    <= in_raw[g];
        s2_q[g]    <= s1_q[g];
        prev_q[g]  <= s2_q[g][5:0];
        latch_q[g] <= (latch_q[g] & keep[g]) | ev[g];
        if (wr_slot[g]) mask_q[g] <= reg_wdata_i[30:24];
      end
    end

    assign pend[g]      = |(latch_q[g] & ~mask_q[g][4:0]);
    assign serr_slot[g] = (latch_q[g][3] & ~mask_q[g][5]) |
                          (latch_q[g][4] & ~mask_q[g][6]);
    assign slot_word[g] = {1'b0, mask_q[g], 3'b0, latch_q[g], 4'b0,
                           s2_q[g][1:0], s2_q[g][6], s2_q[g][3], s2_q[g][2],
                           ~(s2_q[g][4] | s2_q[g][5]), 6'b0};

    assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q[g] & $past(latch_q[g] & keep[g])) == $past(latch_q[g] & keep[g]));
    assert_mask_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_slot[g] |=> (mask_q[g] == $past(reg_wdata_i[30:24])));
    assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> (latch_q[g] == 5'b0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q     <= '0;
      gim_q     <= 1'b1;
      gserr_q   <= 1'b1;
      arbm_q    <= 1'b1;
      arb_det_q <= 1'b0;
    end else begin
      if (!armed) arm_q <= arm_q + 2'd1;
      if (wr_ctl) begin
        gim_q   <= reg_wdata_i[0];
        gserr_q <= reg_wdata_i[1];
        arbm_q  <= reg_wdata_i[3];
      end
      arb_det_q <= (arb_det_q & ~(wr_ctl & reg_wdata_i[17])) | arb_err_i;
    end
  end

  assign ctrl_word = {14'b0, arb_det_q, 13'b0, arbm_q, 1'b0, gserr_q, gim_q};

  always_comb begin
    loc    = '0;
    loc[0] = cmd_pend_i;
    for (int i = 0; i < NUM_SLOTS; i++) loc[i+1] = pend[i];
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == AW'(0)) reg_rdata_o = ctrl_word;
    else if (reg_addr_i == AW'(1)) reg_rdata_o = loc;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (reg_addr_i == AW'(i + 2)) reg_rdata_o = slot_word[i];
  end

  assign irq_o  = (|loc) & ~gim_q;
  assign serr_o = ~gserr_q & ((|serr_slot) | (arb_det_q & ~arbm_q));

  assert_arb_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arb_err_i |=> arb_det_q);
  assert_cmd_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pend_i && !gim_q) |-> irq_o);

endmodule

// File: tb/slot_event_ctrl_tb_top.sv
module slot_event_ctrl_tb_top;
  localparam int N  = 4;
  localparam int AW = $clog2(N + 2);

  // {slot[2], pres[2], btn, lat, iso, con, cap, exp status 11:6, exp latch 20:16}
  localparam logic [19:0] VEC [8] = '{
    20'b00_01_0_0_0_0_1_011001_00001,
    20'b01_11_1_0_0_0_0_110011_00100,
    20'b10_11_0_1_1_0_0_110100_01010,
    20'b11_11_0_0_0_1_0_110000_10000,
    20'b00_01_0_0_0_0_0_010001_00000,
    20'b01_10_0_0_0_0_0_100001_00101,
    20'b11_11_0_0_1_0_0_110000_10010,
    20'b10_00_0_1_1_0_0_000100_00001
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2*N-1:0] pres = '1;
  logic [N-1:0] btn = '0, lat = '0, iso = '0, con = '0, cap = '0;
  logic cmd = 1'b0, arb = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata, v;
  logic irq, serr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  slot_event_ctrl #(.NUM_SLOTS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .pres_code_i(pres), .button_i(btn),
    .latch_open_i(lat), .iso_fault_i(iso), .con_fault_i(con), .cap66_i(cap),
    .cmd_pend_i(cmd), .arb_err_i(arb), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .serr_o(serr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    we = 1'b1; addr = AW'(a); wdata = d;
    @(posedge clk); @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = AW'(a); #1; d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    rd(0, v); chk("R1 ctrl reset", v, 32'h0000000B);
    rd(2, v); chk("R1 slot0 reset", v, 32'h7F000C40);
    rd(5, v); chk("R11 slot3 no event after reset", {27'b0, v[20:16]}, 32'h0);
    rd(1, v); chk("R1 locator reset", v, 32'h0);
    chk("R1 irq/serr reset", {30'b0, irq, serr}, 32'h0);

    wr(2, 32'hFFFFFFFF); rd(2, v); chk("R6 slot reserved bits", v, 32'h7F000C40);
    wr(0, 32'hFFFFFFFF); rd(0, v); chk("R6 ctrl reserved bits", v, 32'h0000000B);

    wr(0, 32'h0);
    for (int s = 0; s < N; s++) wr(s + 2, 32'h001F0000);

    for (int k = 0; k < 8; k++) begin
      automatic int s = int'(VEC[k][19:18]);
      wr(s + 2, 32'h001F0000);
      pres[2*s +: 2] = VEC[k][17:16];
      btn[s] = VEC[k][15]; lat[s] = VEC[k][14]; iso[s] = VEC[k][13];
      con[s] = VEC[k][12]; cap[s] = VEC[k][11];
      settle();
      rd(s + 2, v);
      chk($sformatf("R2 status vec%0d", k), {26'b0, v[11:6]}, {26'b0, VEC[k][10:5]});
      chk($sformatf("R3 latch vec%0d", k), {27'b0, v[20:16]}, {27'b0, VEC[k][4:0]});
      rd(1, v);
      chk($sformatf("R7 locator bit vec%0d", k), {31'b0, v[s+1]}, {31'b0, |VEC[k][4:0]});
    end

    for (int s = 0; s < N; s++) wr(s + 2, 32'h001F0000);
    rd(1, v); chk("R4 all cleared", v, 32'h0);

    btn[0] = 1'b1; settle();
    rd(2, v); chk("R3 button latch", {27'b0, v[20:16]}, 32'h4);
    wr(2, 32'h0); rd(2, v); chk("R4 write zero keeps", {27'b0, v[20:16]}, 32'h4);
    wr(2, 32'h00040000); rd(2, v); chk("R4 w1c clears", {27'b0, v[20:16]}, 32'h0);
    btn[0] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(2, 32'h00040000); rd(2, v); chk("R4 event wins over clear", {27'b0, v[20:16]}, 32'h4);
    wr(2, 32'h001F0000);

    lat[3] = 1'b1; settle();
    chk("R9 serr latch change", {31'b0, serr}, 32'h1);
    rd(1, v); chk("R7 slot3 locator", v, 32'h10);
    wr(5, 32'h20000000); chk("R5 serr mask bit29", {31'b0, serr}, 32'h0);
    wr(5, 32'h28000000); rd(1, v); chk("R5 intr mask bit27", v, 32'h0);
    chk("R8 irq low masked event", {31'b0, irq}, 32'h0);
    wr(5, 32'h0); chk("R9 serr unmasked", {31'b0, serr}, 32'h1);
    wr(0, 32'h2); chk("R9 global serr mask", {31'b0, serr}, 32'h0);
    wr(0, 32'h0); wr(5, 32'h001F0000); chk("R9 serr after clear", {31'b0, serr}, 32'h0);

    btn[1] = 1'b1; settle();
    chk("R8 irq on slot1", {31'b0, irq}, 32'h1);
    wr(0, 32'h1); rd(1, v); chk("R7 locator slot1", v, 32'h4);
    chk("R8 global intr mask", {31'b0, irq}, 32'h0);
    wr(0, 32'h0); wr(3, 32'h001F0000);

    cmd = 1'b1; rd(1, v); chk("R7 cmd bit", v, 32'h1);
    chk("R8 irq from cmd", {31'b0, irq}, 32'h1);
    wr(1, 32'hFFFFFFFF); rd(1, v); chk("R7 locator read-only", v, 32'h1);
    cmd = 1'b0;

    arb = 1'b1; @(posedge clk); @(negedge clk); arb = 1'b0;
    rd(0, v); chk("R10 arbiter latch", v, 32'h00020000);
    chk("R9 serr arbiter", {31'b0, serr}, 32'h1);
    wr(0, 32'h00020000); rd(0, v); chk("R10 arbiter w1c", v, 32'h0);
    chk("R9 serr arbiter cleared", {31'b0, serr}, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule